// File: doc/BRIEF.md
# Watchdog Reset Supervisor

This block supervises a host processor and drives its reset line. It holds reset for a fixed hold interval after power-on and after every low-supply episode. While the host runs, it watches for bus activity. Each start condition reported by an external two-wire start detector restarts the watchdog count. If no start arrives within the selected period, the block drives reset for one hold interval. It then releases reset and begins counting again.

All durations are counted in ticks of an internal prescaler. One tick is `TICK_CYCLES` clock cycles, nominally one millisecond. The defaults give a 200 ms hold and watchdog periods of 1400, 600 and 200 ms. A bench can shrink every value to a few cycles. The period code comes from a configuration field whose reset value is `11` (watchdog off). Reset is presented in both polarities.

The controller has five states. `ST_PWRUP` times the hold interval. `ST_BROWNOUT` waits while the supply is low. `ST_WATCH` counts toward a timeout. `ST_PARKED` is the watchdog-off state. `ST_BITE` times the reset pulse after a timeout. The transitions are:

- **Low-supply entry:** any state goes to `ST_BROWNOUT` while `low_supply` is high.
- **Brownout exit:** `ST_BROWNOUT` goes to `ST_PWRUP` when the flag clears.
- **Hold done:** `ST_PWRUP` goes to `ST_WATCH`, or to `ST_PARKED` if the code is `11`.
- **Timeout:** `ST_WATCH` goes to `ST_BITE`.
- **Bite done:** `ST_BITE` goes to `ST_WATCH`, or to `ST_PARKED` if the code is `11`.
- **Disable:** `ST_WATCH` goes to `ST_PARKED` when the code changes to `11`.
- **Enable:** `ST_PARKED` goes to `ST_WATCH` when the code changes to any other value.

Top module: `wdog_supervisor`

## Requirements
- R1: While `por_n` is low, reset is active. After `por_n` rises, reset stays active for exactly `HOLD_TICKS*TICK_CYCLES` clock edges, then releases.
- R2: `rst_out` is always the inverse of `rst_out_n`.
- R3: In `ST_WATCH` with code `00`, `01` or `10`, reset asserts `LONG_TICKS`, `MID_TICKS` or `SHORT_TICKS` ticks after the last restart. A restart is entry to watching, a start pulse, or a code change. One tick is `TICK_CYCLES` clock edges.
- R4: Code `11` disables the watchdog, so reset never asserts from a timeout. This code is the configuration reset value.
- R5: A timeout drives reset for exactly `HOLD_TICKS` ticks. After release, the count restarts from zero, so the next timeout comes one full period after the release.
- R6: A one-cycle `bus_start` pulse while watching restarts the count from zero.
- R7: While `low_supply` is high, reset is active in the same cycle. After the flag clears, one edge passes and then a full hold interval is timed before release.
- R8: Changing `period_sel` while watching restarts the count from zero under the new period. Changing it to `11` stops the watchdog.
- R9: `bus_start` pulses while a timeout reset is being driven are ignored, and the reset length is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on indication, low while power is not yet good (asynchronous) |
| low_supply | input | 1 | Low-supply flag, high while the supply is below its trip level |
| bus_start | input | 1 | One-cycle pulse from the two-wire bus start detector |
| period_sel | input | 2 | Watchdog period code: 00 longest, 01 middle, 10 shortest, 11 off |
| rst_out_n | output | 1 | Reset, active low |
| rst_out | output | 1 | Reset, active high |

## Verification
Each enabled period code is tried three ways: from the disabled state, mid-count from another code, and repeatedly after its own timeout. Edge-exact lengths separate a prescaler error from a wrong period limit, and show whether the count truly restarts after release. Start pulses arrive just before expiry, which shows a restart rather than a paused count; a continuous start level during a reset pulse must leave that pulse's length unchanged. Low-supply episodes and a long parked stretch under code `11` separate the brownout path from the timeout path.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP    = 3'd0,
        ST_BROWNOUT = 3'd1,
        ST_WATCH    = 3'd2,
        ST_PARKED   = 3'd3,
        ST_BITE     = 3'd4
    } wdg_state_t;

    localparam logic [1:0] SEL_LONG  = 2'b00;
    localparam logic [1:0] SEL_MID   = 2'b01;
    localparam logic [1:0] SEL_SHORT = 2'b10;
    localparam logic [1:0] SEL_OFF   = 2'b11;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wdg_prescaler.sv
`timescale 1ns/1ps
module wdg_prescaler #(
    parameter int TICK_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr || pre_q == LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = (pre_q == LAST);

    // R3: the phase counter never leaves its range
    a_r3_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= LAST);

endmodule

// File: rtl/wdg_interval.sv
`timescale 1ns/1ps
module wdg_interval #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = tick && (cnt_q == limit - 1'b1);

    // R5: the count stays below the limit chosen by the controller
    a_r5_cnt_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < limit);

endmodule

// File: rtl/wdg_period_map.sv
`timescale 1ns/1ps
module wdg_period_map
    import wdg_pkg::*;
#(
    parameter int CW          = 11,
    parameter int LONG_TICKS  = 1400,
    parameter int MID_TICKS   = 600,
    parameter int SHORT_TICKS = 200
) (
    input  logic [1:0]    sel,
    output logic [CW-1:0] limit,
    output logic          off
);
    always_comb begin
        limit = CW'(1);
        off   = 1'b0;
        unique case (sel)
            SEL_LONG:  limit = CW'(LONG_TICKS);
            SEL_MID:   limit = CW'(MID_TICKS);
            SEL_SHORT: limit = CW'(SHORT_TICKS);
            SEL_OFF:   off   = 1'b1;
        endcase
    end

endmodule

// File: rtl/wdog_supervisor.sv
`timescale 1ns/1ps
module wdog_supervisor
    import wdg_pkg::*;
#(
    parameter int TICK_CYCLES = 50000,
    parameter int HOLD_TICKS  = 200,
    parameter int LONG_TICKS  = 1400,
    parameter int MID_TICKS   = 600,
    parameter int SHORT_TICKS = 200
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       low_supply,
    input  logic       bus_start,
    input  logic [1:0] period_sel,
    output logic       rst_out_n,
    output logic       rst_out
);
    localparam int MAXT = max_of(max_of(HOLD_TICKS, LONG_TICKS), max_of(MID_TICKS, SHORT_TICKS));
    localparam int CW   = $clog2(MAXT + 1);

    wdg_state_t    state_q, state_d;
    logic [1:0]    sel_q;
    logic          sel_change;
    logic          restart;
    logic          tick;
    logic          ivl_done;
    logic [CW-1:0] per_limit;
    logic          per_off;
    logic [CW-1:0] ivl_limit;
    logic          reset_state;

    assign sel_change = (period_sel != sel_q);

    wdg_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (restart),
        .tick  (tick)
    );

    wdg_period_map #(
        .CW          (CW),
        .LONG_TICKS  (LONG_TICKS),
        .MID_TICKS   (MID_TICKS),
        .SHORT_TICKS (SHORT_TICKS)
    ) u_map (
        .sel   (sel_q),
        .limit (per_limit),
        .off   (per_off)
    );

    assign ivl_limit = (state_q == ST_PWRUP || state_q == ST_BITE) ? CW'(HOLD_TICKS) : per_limit;

    wdg_interval #(.CW(CW)) u_ivl (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (restart),
        .tick  (tick),
        .limit (ivl_limit),
        .done  (ivl_done)
    );

    // state register and configuration capture
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_PWRUP;
            sel_q   <= SEL_OFF;
        end else begin
            state_q <= state_d;
            sel_q   <= period_sel;
        end
    end

    // next state and restart of the timing chain
    always_comb begin
        state_d = state_q;
        restart = 1'b0;
        if (low_supply) begin
            state_d = ST_BROWNOUT;
            restart = 1'b1;
        end else begin
            unique case (state_q)
                ST_PWRUP: begin
                    if (ivl_done) begin
                        state_d = (period_sel == SEL_OFF) ? ST_PARKED : ST_WATCH;
                        restart = 1'b1;
                    end
                end
                ST_BROWNOUT: begin
                    state_d = ST_PWRUP;
                    restart = 1'b1;
                end
                ST_WATCH: begin
                    if (sel_change && period_sel == SEL_OFF) begin
                        state_d = ST_PARKED;
                        restart = 1'b1;
                    end else if (bus_start || sel_change) begin
                        restart = 1'b1;
                    end else if (ivl_done && !per_off) begin
                        state_d = ST_BITE;
                        restart = 1'b1;
                    end
                end
                ST_PARKED: begin
                    restart = 1'b1;
                    if (sel_change && period_sel != SEL_OFF) begin
                        state_d = ST_WATCH;
                    end
                end
                ST_BITE: begin
                    if (ivl_done) begin
                        state_d = (period_sel == SEL_OFF) ? ST_PARKED : ST_WATCH;
                        restart = 1'b1;
                    end
                end
                default: begin
                    state_d = ST_PWRUP;
                    restart = 1'b1;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_PWRUP, ST_BROWNOUT, ST_BITE: reset_state = 1'b1;
            ST_WATCH, ST_PARKED:            reset_state = 1'b0;
            default:                        reset_state = 1'b1;
        endcase
        rst_out   = reset_state | low_supply | ~por_n;
        rst_out_n = ~rst_out;
    end

    // R1: the hold interval is not cut short
    a_r1_hold_kept: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_PWRUP && !low_supply && !ivl_done) |=> state_q == ST_PWRUP);

    // R3: a timeout reset is only ever entered from watching
    a_r3_bite_from_watch: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_BITE && $past(state_q) != ST_BITE) |-> $past(state_q) == ST_WATCH);

    // R4: the off code never leads to a timeout
    a_r4_parked_holds: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_PARKED && !low_supply && period_sel == SEL_OFF) |=> state_q == ST_PARKED);

    // R6: a start pulse keeps the controller watching
    a_r6_start_keeps_watch: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_WATCH && bus_start && !low_supply && !sel_change) |=> state_q == ST_WATCH);

    // R7: low supply always lands in the brownout state
    a_r7_brownout_entry: assert property (@(posedge clk) disable iff (!por_n)
        low_supply |=> state_q == ST_BROWNOUT);

    // R9: start pulses cannot shorten a timeout reset
    a_r9_bite_ignores_start: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_BITE && !low_supply && !ivl_done) |=> state_q == ST_BITE);

endmodule

// File: tb/tb_wdog_supervisor.sv
`timescale 1ns/1ps
module tb_wdog_supervisor;

    localparam int TC  = 3;
    localparam int HT  = 4;
    localparam int LT  = 10;
    localparam int MT  = 7;
    localparam int ST  = 5;
    localparam int HOLD_E = HT * TC;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       low_supply = 1'b0;
    logic       bus_start = 1'b0;
    logic [1:0] period_sel = 2'b11;
    logic       rst_out_n;
    logic       rst_out;

    int total = 0;
    int bad = 0;
    int pol_err = 0;

    always #2.5 clk = ~clk;

    wdog_supervisor #(
        .TICK_CYCLES (TC),
        .HOLD_TICKS  (HT),
        .LONG_TICKS  (LT),
        .MID_TICKS   (MT),
        .SHORT_TICKS (ST)
    ) dut (
        .clk        (clk),
        .por_n      (por_n),
        .low_supply (low_supply),
        .bus_start  (bus_start),
        .period_sel (period_sel),
        .rst_out_n  (rst_out_n),
        .rst_out    (rst_out)
    );

    function automatic int period_edges(input logic [1:0] c);
        case (c)
            2'b00:   return LT * TC;
            2'b01:   return MT * TC;
            2'b10:   return ST * TC;
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sample_pol();
        if (rst_out != ~rst_out_n) pol_err++;
    endtask

    // edges until reset asserts
    task automatic to_assert(input string req, input int exp);
        int n = 0;
        do begin
            @(posedge clk); #1;
            n++;
            sample_pol();
        end while (rst_out_n && n < 2000);
        check(n == exp, req, n, exp);
    endtask

    // edges until reset releases
    task automatic to_release(input string req, input int exp);
        int n = 0;
        do begin
            @(posedge clk); #1;
            n++;
            sample_pol();
        end while (!rst_out_n && n < 2000);
        check(n == exp, req, n, exp);
    endtask

    // n edges during which reset must stay in the given level
    task automatic hold_level(input int n, input logic want_n, input string req);
        int err = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            sample_pol();
            if (rst_out_n != want_n) err++;
        end
        check(err == 0, req, err, 0);
    endtask

    task automatic set_sel(input logic [1:0] c);
        @(negedge clk); period_sel = c;
        @(posedge clk); #1;
    endtask

    task automatic kick();
        @(negedge clk); bus_start = 1'b1;
        @(posedge clk); #1;
        bus_start = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state while power is not good
        repeat (3) @(posedge clk);
        #1;
        check(rst_out_n == 1'b0, "R1 por low rst_out_n", rst_out_n, 0);
        check(rst_out == 1'b1, "R1 por low rst_out", rst_out, 1);
        @(negedge clk); por_n = 1'b1;
        to_release("R1 hold after power-on", HOLD_E);

        // R4: off code by default, no timeout
        hold_level(120, 1'b1, "R4 parked no reset");

        // R3 / R5: sweep of enabled codes
        for (int c = 0; c < 3; c++) begin
            set_sel(c[1:0]);
            to_assert("R3 first timeout", period_edges(c[1:0]));
            to_release("R5 bite length", HOLD_E);
            to_assert("R5 restart after bite", period_edges(c[1:0]));
            to_release("R5 bite length again", HOLD_E);
        end

        // R6: start pulses just before expiry keep resetting the count
        for (int k = 0; k < 4; k++) begin
            hold_level(period_edges(2'b10) - 2, 1'b1, "R6 no reset before kick");
            kick();
        end
        to_assert("R6 timeout after last kick", period_edges(2'b10));

        // R9: continuous start level during the bite does not change it
        @(negedge clk); bus_start = 1'b1;
        to_release("R9 bite length with starts", HOLD_E);
        @(negedge clk); bus_start = 1'b0;

        // R8: code change mid-count restarts with the new period
        set_sel(2'b00);
        hold_level(20, 1'b1, "R8 counting long");
        set_sel(2'b10);
        to_assert("R8 new period from zero", period_edges(2'b10));
        to_release("R5 bite after change", HOLD_E);
        set_sel(2'b00);
        hold_level(10, 1'b1, "R8 counting before off");
        set_sel(2'b11);
        hold_level(200, 1'b1, "R8 R4 off stops watchdog");
        set_sel(2'b01);
        to_assert("R8 enable from off", period_edges(2'b01));
        to_release("R5 bite mid code", HOLD_E);

        // R7: low supply
        hold_level(5, 1'b1, "R7 running before low supply");
        @(negedge clk); low_supply = 1'b1;
        #1;
        check(rst_out_n == 1'b0, "R7 same-cycle reset", rst_out_n, 0);
        hold_level(25, 1'b0, "R7 reset held while low");
        @(negedge clk); low_supply = 1'b0;
        @(posedge clk); #1;
        sample_pol();
        check(rst_out_n == 1'b0, "R7 still active at clear edge", rst_out_n, 0);
        to_release("R7 hold after low supply", HOLD_E);

        // R7: low supply during a timeout reset
        to_assert("R3 timeout before brownout", period_edges(2'b01));
        hold_level(3, 1'b0, "R5 bite active");
        @(negedge clk); low_supply = 1'b1;
        hold_level(4, 1'b0, "R7 low during bite");
        @(negedge clk); low_supply = 1'b0;
        @(posedge clk); #1;
        to_release("R7 full hold after bite brownout", HOLD_E);

        check(pol_err == 0, "R2 polarity", pol_err, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule